// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small accumulator processor. It uses 16-bit words and a word-addressed memory of up to 4096 words. Every instruction passes through a fixed multicycle sequence built on five registers:

- a program counter;
- a memory address register;
- a memory data buffer;
- an instruction register;
- an accumulator.

An instruction word holds a 4-bit opcode in bits 15:12 and a 12-bit address field in bits 11:0. The sequence runs in three parts:

- **Fetch.** The core copies the program counter into the address register. It then captures the memory word into the instruction register and advances the program counter by one.
- **Decode.** The core copies the address field into the address register.
- **Execute.** An operand is staged through the address register and the data buffer, and each transfer takes its own cycle.

The core connects to a synchronous single-port memory. That memory returns the word at the presented address one clock after that address is presented. The core also has three other connections:

- a polled input register, with a valid flag and a one-clock acknowledge;
- an output register, with a one-clock strobe;
- a halted flag.

Once the core has halted, it stays halted until reset. Add and subtract wrap modulo 2^16 in two's complement. No flags are kept.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held, and in the first cycle after it, halted, out_strobe, in_ack and mem_we are 0, out_data is 0 and mem_addr is 0.
- R2: Execution starts at address 0 and proceeds to the next sequential address after each instruction, except where a jump or a skip applies.
- R3: Opcode 1 loads M[X] into the accumulator. Opcode 3 sets it to acc + M[X], and opcode 4 sets it to acc - M[X]. Both results wrap modulo 2^16.
- R4: Opcode 2 writes the accumulator to M[X] with mem_we high for exactly one cycle.
- R5: Opcode 8 skips the next instruction when the condition in bits 11:10 holds. The codes are 00 for acc negative (bit 15 set), 01 for acc zero, and 10 for acc positive and non-zero. Code 11 never skips.
- R6: Opcode 9 continues execution at address X unconditionally.
- R7: Opcode 5 waits with in_ack low while in_valid is low. When it sees in_valid, it copies in_data into the accumulator and raises in_ack for exactly that one cycle.
- R8: Opcode 6 copies the accumulator to out_data and raises out_strobe for exactly one cycle. Between strobes out_data does not change.
- R9: Opcode 7 sets halted. Halted stays high until reset. While halted there are no memory writes, no strobes and no change of mem_addr.
- R10: Opcodes 0 and 10 to 15 change no visible state, and execution continues at the next address.
- R11: Each word read from memory, whether instruction or operand, is taken from an address that has been held on mem_addr for at least one full cycle before the capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address, the address register value |
| mem_wdata | output | 16 | Memory write data, the data buffer value |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| in_data | input | 16 | Input register value |
| in_valid | input | 1 | Input data present |
| in_ack | output | 1 | One-cycle pulse when the input is consumed |
| out_data | output | 16 | Output register |
| out_strobe | output | 1 | One-cycle pulse when out_data is updated |
| halted | output | 1 | Core has executed a halt |

## Verification
Wrong internal state shows up at the ports in one of two ways:

- **Accumulator, buffer or address-register corruption.** This changes the value that the next output instruction presents on out_data. It also changes the address and data of the next memory write. Each program therefore ends in an output or a store, a few cycles after the faulty step.
- **Program-counter or sequencing faults.** A bad skip, a bad jump or a lost increment makes the program run the wrong instruction. The symptom is a wrong value, a missing or extra strobe, or a halt that never comes. The per-program timeout catches the last case within a few hundred cycles.

Sticky-halt and single-pulse faults show within one cycle as an extra write, an extra strobe or an extra acknowledge.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_BITS = 4;

   localparam logic [OPC_BITS-1:0] OP_LOAD   = 4'h1;
   localparam logic [OPC_BITS-1:0] OP_STORE  = 4'h2;
   localparam logic [OPC_BITS-1:0] OP_ADD    = 4'h3;
   localparam logic [OPC_BITS-1:0] OP_SUB    = 4'h4;
   localparam logic [OPC_BITS-1:0] OP_INPUT  = 4'h5;
   localparam logic [OPC_BITS-1:0] OP_OUTPUT = 4'h6;
   localparam logic [OPC_BITS-1:0] OP_HALT   = 4'h7;
   localparam logic [OPC_BITS-1:0] OP_SKIP   = 4'h8;
   localparam logic [OPC_BITS-1:0] OP_JUMP   = 4'h9;

   typedef enum logic [3:0] {
      PH_FETCH_A,
      PH_FETCH_B,
      PH_FETCH_C,
      PH_DECODE,
      PH_EXEC,
      PH_CAPT,
      PH_ACC,
      PH_WRITE,
      PH_IN_WAIT,
      PH_HALT
   } phase_t;

   typedef enum logic [2:0] {
      AC_HOLD,
      AC_MBR,
      AC_ADD,
      AC_SUB,
      AC_IN
   } ac_src_t;

   typedef struct packed {
      logic    mar_pc;
      logic    mar_ir;
      logic    ir_ld;
      logic    pc_inc;
      logic    pc_jmp;
      logic    mbr_mem;
      logic    mbr_ac;
      logic    out_ld;
      ac_src_t ac_sel;
   } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
   parameter int WORD_W        = 16,
   parameter bit SUB_BY_NEGATE = 1'b1
) (
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic [1:0]        cond,
   output logic [WORD_W-1:0] sum,
   output logic [WORD_W-1:0] diff,
   output logic              skip_take
);

   localparam logic [WORD_W-1:0] ONE = 1;

   logic is_neg;
   logic is_zero;
   logic is_pos;

   assign sum = a + b;

   generate
      if (SUB_BY_NEGATE) begin : g_sub_neg
         assign diff = a + (~b) + ONE;
      end else begin : g_sub_direct
         assign diff = a - b;
      end
   endgenerate

   assign is_neg  = a[WORD_W-1];
   assign is_zero = (a == '0);
   assign is_pos  = !is_neg && !is_zero;

   always_comb begin
      case (cond)
         2'b00:   skip_take = is_neg;
         2'b01:   skip_take = is_zero;
         2'b10:   skip_take = is_pos;
         default: skip_take = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic [OPC_BITS-1:0] opcode,
   input  logic                skip_take,
   input  logic                in_valid,
   output ctl_t                ctl,
   output logic                mem_we,
   output logic                in_ack,
   output logic                halted
);

   phase_t st;
   phase_t st_nx;

   always_ff @(posedge clk) begin
      if (rst) st <= PH_FETCH_A;
      else     st <= st_nx;
   end

   always_comb begin
      ctl        = '0;
      ctl.ac_sel = AC_HOLD;
      mem_we     = 1'b0;
      in_ack     = 1'b0;
      st_nx      = st;
      case (st)
         PH_FETCH_A: begin
            ctl.mar_pc = 1'b1;
            st_nx      = PH_FETCH_B;
         end
         PH_FETCH_B: st_nx = PH_FETCH_C;
         PH_FETCH_C: begin
            ctl.ir_ld  = 1'b1;
            ctl.pc_inc = 1'b1;
            st_nx      = PH_DECODE;
         end
         PH_DECODE: begin
            ctl.mar_ir = 1'b1;
            st_nx      = PH_EXEC;
         end
         PH_EXEC: begin
            case (opcode)
               OP_LOAD, OP_ADD, OP_SUB: st_nx = PH_CAPT;
               OP_STORE: begin
                  ctl.mbr_ac = 1'b1;
                  st_nx      = PH_WRITE;
               end
               OP_INPUT: st_nx = PH_IN_WAIT;
               OP_OUTPUT: begin
                  ctl.out_ld = 1'b1;
                  st_nx      = PH_FETCH_A;
               end
               OP_HALT: st_nx = PH_HALT;
               OP_SKIP: begin
                  ctl.pc_inc = skip_take;
                  st_nx      = PH_FETCH_A;
               end
               OP_JUMP: begin
                  ctl.pc_jmp = 1'b1;
                  st_nx      = PH_FETCH_A;
               end
               default: st_nx = PH_FETCH_A;
            endcase
         end
         PH_CAPT: begin
            ctl.mbr_mem = 1'b1;
            st_nx       = PH_ACC;
         end
         PH_ACC: begin
            case (opcode)
               OP_ADD:  ctl.ac_sel = AC_ADD;
               OP_SUB:  ctl.ac_sel = AC_SUB;
               default: ctl.ac_sel = AC_MBR;
            endcase
            st_nx = PH_FETCH_A;
         end
         PH_WRITE: begin
            mem_we = 1'b1;
            st_nx  = PH_FETCH_A;
         end
         PH_IN_WAIT: begin
            if (in_valid) begin
               in_ack     = 1'b1;
               ctl.ac_sel = AC_IN;
               st_nx      = PH_FETCH_A;
            end
         end
         PH_HALT: st_nx = PH_HALT;
         default: st_nx = PH_FETCH_A;
      endcase
   end

   assign halted = (st == PH_HALT);

   // R9: halt is sticky
   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   // R9: no memory write while halted
   p_no_write_halted_r9: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we);

   // R4: write enable lasts one cycle
   p_we_single_r4: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);

   // R7: acknowledge lasts one cycle
   p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
      in_ack |=> !in_ack);

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
   import acc_cpu_pkg::*;
#(
   parameter int WORD_W        = 16,
   parameter int ADDR_W        = 12,
   parameter bit SUB_BY_NEGATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  ctl_t                ctl,
   input  logic [WORD_W-1:0]   mem_rdata,
   input  logic [WORD_W-1:0]   in_data,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [WORD_W-1:0]   mem_wdata,
   output logic [OPC_BITS-1:0] opcode,
   output logic                skip_take,
   output logic [WORD_W-1:0]   out_data,
   output logic                out_strobe
);

   localparam logic [ADDR_W-1:0] PC_STEP = 1;

   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] mar;
   logic [WORD_W-1:0] mbr;
   logic [WORD_W-1:0] ir;
   logic [WORD_W-1:0] ac;
   logic [WORD_W-1:0] sum;
   logic [WORD_W-1:0] diff;

   acc_cpu_alu #(
      .WORD_W        (WORD_W),
      .SUB_BY_NEGATE (SUB_BY_NEGATE)
   ) u_alu (
      .a         (ac),
      .b         (mbr),
      .cond      (ir[ADDR_W-1 -: 2]),
      .sum       (sum),
      .diff      (diff),
      .skip_take (skip_take)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc         <= '0;
         mar        <= '0;
         mbr        <= '0;
         ir         <= '0;
         ac         <= '0;
         out_data   <= '0;
         out_strobe <= 1'b0;
      end else begin
         if (ctl.mar_pc)      mar <= pc;
         else if (ctl.mar_ir) mar <= ir[ADDR_W-1:0];

         if (ctl.ir_ld) ir <= mem_rdata;

         if (ctl.pc_jmp)      pc <= ir[ADDR_W-1:0];
         else if (ctl.pc_inc) pc <= pc + PC_STEP;

         if (ctl.mbr_mem)     mbr <= mem_rdata;
         else if (ctl.mbr_ac) mbr <= ac;

         case (ctl.ac_sel)
            AC_MBR:  ac <= mbr;
            AC_ADD:  ac <= sum;
            AC_SUB:  ac <= diff;
            AC_IN:   ac <= in_data;
            default: ac <= ac;
         endcase

         out_strobe <= ctl.out_ld;
         if (ctl.out_ld) out_data <= ac;
      end
   end

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign opcode    = ir[WORD_W-1 -: OPC_BITS];

   // R11: operand capture uses an address held since the previous cycle
   p_mbr_after_mar_r11: assert property (@(posedge clk) disable iff (rst)
      ctl.mbr_mem |-> $stable(mar));

   // R11: instruction capture uses an address held since the previous cycle
   p_ir_after_mar_r11: assert property (@(posedge clk) disable iff (rst)
      ctl.ir_ld |-> $stable(mar));

   // R8: strobe lasts one cycle
   p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
      out_strobe |=> !out_strobe);

   // R8: output register only moves with a strobe
   p_out_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      !out_strobe |-> $stable(out_data));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int WORD_W        = 16,
   parameter int OPC_W         = 4,
   parameter bit SUB_BY_NEGATE = 1'b1,
   localparam int ADDR_W       = WORD_W - OPC_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ack,
   output logic [WORD_W-1:0] out_data,
   output logic              out_strobe,
   output logic              halted
);

   generate
      if (OPC_W != OPC_BITS) begin : g_bad_opc
         $error("acc_cpu_core: OPC_W must match the opcode encoding width");
      end
      if (ADDR_W < 2) begin : g_bad_width
         $error("acc_cpu_core: address field too narrow for skip condition");
      end
   endgenerate

   ctl_t                ctl;
   logic [OPC_BITS-1:0] opcode;
   logic                skip_take;

   acc_cpu_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .opcode    (opcode),
      .skip_take (skip_take),
      .in_valid  (in_valid),
      .ctl       (ctl),
      .mem_we    (mem_we),
      .in_ack    (in_ack),
      .halted    (halted)
   );

   acc_cpu_datapath #(
      .WORD_W        (WORD_W),
      .ADDR_W        (ADDR_W),
      .SUB_BY_NEGATE (SUB_BY_NEGATE)
   ) u_dp (
      .clk        (clk),
      .rst        (rst),
      .ctl        (ctl),
      .mem_rdata  (mem_rdata),
      .in_data    (in_data),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .opcode     (opcode),
      .skip_take  (skip_take),
      .out_data   (out_data),
      .out_strobe (out_strobe)
   );

   // R9: address frozen once halted
   p_halt_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      halted |=> $stable(mem_addr));

   // R9: no strobe while halted
   p_halt_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
      halted |=> !out_strobe);

endmodule

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic [15:0] mem_rdata;
   logic [15:0] in_data = 16'h0;
   logic        in_valid = 1'b0;
   logic        in_ack;
   logic [15:0] out_data;
   logic        out_strobe;
   logic        halted;

   logic        ld_we = 1'b0;
   logic [11:0] ld_addr = 12'h0;
   logic [15:0] ld_data = 16'h0;

   logic [15:0] mem [4096];
   int          wr_cnt;
   logic [11:0] last_wr_addr;
   logic [15:0] last_wr_data;
   int          stb_cnt;
   logic [15:0] last_out;
   int          ack_cnt;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   acc_cpu_core u0 (
      .clk        (clk),
      .rst        (rst),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_we     (mem_we),
      .mem_rdata  (mem_rdata),
      .in_data    (in_data),
      .in_valid   (in_valid),
      .in_ack     (in_ack),
      .out_data   (out_data),
      .out_strobe (out_strobe),
      .halted     (halted)
   );

   // synchronous memory model and port monitors
   always @(posedge clk) begin
      if (ld_we) mem[ld_addr] <= ld_data;
      else if (mem_we === 1'b1) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
      if (rst) begin
         wr_cnt       <= 0;
         stb_cnt      <= 0;
         ack_cnt      <= 0;
         last_wr_addr <= '0;
         last_wr_data <= '0;
         last_out     <= '0;
      end else begin
         if (mem_we) begin
            wr_cnt       <= wr_cnt + 1;
            last_wr_addr <= mem_addr;
            last_wr_data <= mem_wdata;
         end
         if (out_strobe) begin
            stb_cnt  <= stb_cnt + 1;
            last_out <= out_data;
         end
         if (in_ack) ack_cnt <= ack_cnt + 1;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic begin_load();
      rst = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic put(input logic [11:0] a, input logic [15:0] d);
      ld_addr = a;
      ld_data = d;
      ld_we   = 1'b1;
      @(negedge clk);
   endtask

   task automatic end_load();
      ld_we = 1'b0;
      rst   = 1'b0;
   endtask

   task automatic wait_halt(input string req);
      for (int i = 0; i < 800; i++) begin
         @(negedge clk);
         if (halted) break;
      end
      chk(req, "halt reached", {31'h0, halted}, 32'h1);
   endtask

   // {kind[1:0], cond[1:0], x, y, expected}; kind 0 add, 1 sub, 2 skip
   localparam logic [51:0] VEC [16] = '{
      {2'd0, 2'd0, 16'h0005, 16'h0007, 16'h000C},
      {2'd0, 2'd0, 16'h0035, 16'hFFE9, 16'h001E},
      {2'd0, 2'd0, 16'hFFFF, 16'h0001, 16'h0000},
      {2'd1, 2'd0, 16'h0003, 16'h0005, 16'hFFFE},
      {2'd1, 2'd0, 16'h8000, 16'h0001, 16'h7FFF},
      {2'd2, 2'd0, 16'h8000, 16'h1111, 16'h8000},
      {2'd2, 2'd0, 16'h0005, 16'h1111, 16'h1111},
      {2'd2, 2'd0, 16'h0000, 16'h1111, 16'h1111},
      {2'd2, 2'd1, 16'h0000, 16'h1111, 16'h0000},
      {2'd2, 2'd1, 16'h0001, 16'h1111, 16'h1111},
      {2'd2, 2'd2, 16'h0001, 16'h1111, 16'h0001},
      {2'd2, 2'd2, 16'h0000, 16'h1111, 16'h1111},
      {2'd2, 2'd2, 16'hFFFF, 16'h1111, 16'h1111},
      {2'd2, 2'd2, 16'h7FFF, 16'h1111, 16'h7FFF},
      {2'd2, 2'd3, 16'h0000, 16'h1111, 16'h1111},
      {2'd2, 2'd3, 16'h0005, 16'h1111, 16'h1111}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [11:0] frozen_addr;
      int          frozen_wr;
      int          frozen_stb;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "halted", {31'h0, halted}, 32'h0);
      chk("R1", "out_strobe", {31'h0, out_strobe}, 32'h0);
      chk("R1", "in_ack", {31'h0, in_ack}, 32'h0);
      chk("R1", "mem_we", {31'h0, mem_we}, 32'h0);
      chk("R1", "out_data", {16'h0, out_data}, 32'h0);
      chk("R1", "mem_addr", {20'h0, mem_addr}, 32'h0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "mem_addr after release", {20'h0, mem_addr}, 32'h0);
      chk("R1", "halted after release", {31'h0, halted}, 32'h0);

      // R3, R5, R8: vector table
      foreach (VEC[i]) begin
         logic [1:0]  kind;
         logic [1:0]  cnd;
         logic [15:0] x;
         logic [15:0] y;
         logic [15:0] e;
         string       rq;
         {kind, cnd, x, y, e} = VEC[i];
         rq = (kind == 2'd2) ? "R5" : "R3";
         begin_load();
         put(12'h000, 16'h1100);
         case (kind)
            2'd0:    put(12'h001, 16'h3101);
            2'd1:    put(12'h001, 16'h4101);
            default: put(12'h001, {4'h8, cnd, 10'h000});
         endcase
         if (kind == 2'd2) begin
            put(12'h002, 16'h1101);
            put(12'h003, 16'h6000);
         end else begin
            put(12'h002, 16'h6000);
            put(12'h003, 16'h7000);
         end
         put(12'h004, 16'h7000);
         put(12'h100, x);
         put(12'h101, y);
         end_load();
         wait_halt(rq);
         chk(rq, $sformatf("vector %0d result", i), {16'h0, last_out}, {16'h0, e});
         chk("R8", $sformatf("vector %0d strobe count", i), stb_cnt, 1);
      end

      // R2: sequential execution with two outputs
      begin_load();
      put(12'h000, 16'h1100);
      put(12'h001, 16'h6000);
      put(12'h002, 16'h3101);
      put(12'h003, 16'h6000);
      put(12'h004, 16'h7000);
      put(12'h100, 16'h0100);
      put(12'h101, 16'h0023);
      end_load();
      wait_halt("R2");
      chk("R2", "strobe count", stb_cnt, 2);
      chk("R2", "last output", {16'h0, last_out}, 32'h0123);

      // R4, R11: store, then halt behaviour R9
      begin_load();
      put(12'h000, 16'h1100);
      put(12'h001, 16'h2120);
      put(12'h002, 16'h7000);
      put(12'h100, 16'hBEEF);
      end_load();
      wait_halt("R4");
      chk("R4", "write count", wr_cnt, 1);
      chk("R4", "write address", {20'h0, last_wr_addr}, 32'h120);
      chk("R11", "loaded then stored data", {16'h0, last_wr_data}, 32'hBEEF);
      chk("R4", "memory word", {16'h0, mem[12'h120]}, 32'hBEEF);
      frozen_addr = mem_addr;
      frozen_wr   = wr_cnt;
      frozen_stb  = stb_cnt;
      repeat (30) @(negedge clk);
      chk("R9", "still halted", {31'h0, halted}, 32'h1);
      chk("R9", "address frozen", {20'h0, mem_addr}, {20'h0, frozen_addr});
      chk("R9", "no writes", wr_cnt, frozen_wr);
      chk("R9", "no strobes", stb_cnt, frozen_stb);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R9", "reset clears halt", {31'h0, halted}, 32'h0);

      // R6: jump over two instructions
      begin_load();
      put(12'h000, 16'h9003);
      put(12'h001, 16'h1101);
      put(12'h002, 16'h6000);
      put(12'h003, 16'h1100);
      put(12'h004, 16'h6000);
      put(12'h005, 16'h7000);
      put(12'h100, 16'h0AAA);
      put(12'h101, 16'h0BBB);
      end_load();
      wait_halt("R6");
      chk("R6", "strobe count", stb_cnt, 1);
      chk("R6", "output", {16'h0, last_out}, 32'h0AAA);

      // R10: undefined opcodes are no-ops
      begin_load();
      put(12'h000, 16'h0000);
      put(12'h001, 16'hA0FF);
      put(12'h002, 16'hF100);
      put(12'h003, 16'h1100);
      put(12'h004, 16'h6000);
      put(12'h005, 16'h7000);
      put(12'h100, 16'h5A5A);
      end_load();
      wait_halt("R10");
      chk("R10", "strobe count", stb_cnt, 1);
      chk("R10", "output", {16'h0, last_out}, 32'h5A5A);
      chk("R10", "no writes", wr_cnt, 0);

      // R7: input waits for valid
      begin_load();
      put(12'h000, 16'h5000);
      put(12'h001, 16'h6000);
      put(12'h002, 16'h7000);
      in_valid = 1'b0;
      end_load();
      repeat (25) @(negedge clk);
      chk("R7", "no ack while invalid", ack_cnt, 0);
      chk("R7", "not halted while waiting", {31'h0, halted}, 32'h0);
      chk("R7", "no output while waiting", stb_cnt, 0);
      in_data  = 16'h1234;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      wait_halt("R7");
      chk("R7", "ack count", ack_cnt, 1);
      chk("R7", "input value output", {16'h0, last_out}, 32'h1234);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule